// File: doc/BRIEF.md
# Reciprocal Multi-Period Frequency Counter

This block measures the frequency of an external square wave. It does so by timing a programmed number of the wave's periods against a fast reference clock. The wave enters on `sig_in`, which is asynchronous to the reference clock. It passes through a synchronizer, and its rising edges are then detected in the reference domain. A one-cycle `arm` strobe clears the counters and latches the compare value. The first rising edge after arming starts the reference tick timer. Every rising edge advances an edge counter. When that counter equals the compare value, the elapsed tick count is captured and `done` pulses.

The compare value is the number of periods to time plus one, because the first edge only starts the timer. With a 16 MHz reference, each tick is 1/16 µs. A compare value of 1001 times 1000 periods, which takes about 8 ms for inputs between 125 and 150 kHz. That allows roughly 100 results per second. Downstream logic turns the result into a frequency as `f = f_ref * (cmp - 1) / ticks`.

If the tick counter saturates before the compare is met, the run ends with `done` and an overflow flag.

Top module: `freqc_top`

## Requirements
- R1: After reset, `done` and `overflow` are 0 and `ticks_out` is 0.
- R2: `ticks_out` equals the number of reference cycles between the first detected rising edge after arming and the rising edge that brings the edge count to the compare value. For a periodic input of P reference cycles, that is `(cmp - 1) * P`.
- R3: `done` is high for exactly one reference cycle, in the same cycle that the new `ticks_out` first appears.
- R4: `ticks_out` holds its value until the next completion. Rising edges that arrive after completion and before the next `arm` change neither `ticks_out` nor `done`.
- R5: `period_cmp` is sampled when `arm` is high. Changes to it during a measurement have no effect on that measurement.
- R6: `arm` aborts any run in progress, clears both counters and clears `overflow`. In the cycle after `arm`, `done` and `overflow` are 0. A new measurement then starts on the next detected rising edge.
- R7: A compare value of 0 or 1 completes on the first detected rising edge, with `ticks_out` = 0.
- R8: If the tick count reaches all ones before the compare is met, the run ends. `done` pulses, `overflow` becomes 1 and `ticks_out` is set to all ones. `overflow` stays set until the next `arm`.
- R9: After `arm`, if no rising edge arrives, `done` stays 0.
- R10: Only rising edges count. The result for a given period does not depend on the duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the tick timer advances once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Square wave being measured, asynchronous |
| arm | input | 1 | One-cycle strobe that clears the counters and starts a new measurement |
| period_cmp | input | CNT_W | Edge-count compare value: periods to time plus one |
| ticks_out | output | TICK_W | Captured elapsed reference ticks |
| done | output | 1 | One-cycle pulse when a measurement ends |
| overflow | output | 1 | Set when the tick counter saturated before the compare was met |

## Verification
The last rising edge of a measurement lands on `sig_in` between clock edges. It crosses two synchronizer flops, and the rising-edge detector then sees it. `done` and `ticks_out` are updated on the following clock edge, three reference edges after the input edge. The detection delay is the same for the first and last edge, so it cancels out of the tick result. The bench drives `sig_in` and `arm` on falling edges and polls `done` on falling edges with a bounded wait. It reads `ticks_out` in the same half-cycle in which `done` is seen. One falling edge later, it checks that `done` has dropped. For the overflow case, the bench builds the block with a 12-bit tick counter, so saturation is reached after 4096 cycles.

// File: rtl/freqc_pkg.sv
package freqc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CLEAR = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RUN   = 2'd3
  } freqc_state_e;
endpackage

// File: rtl/freqc_sync_edge.sv
module freqc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  genvar gi;
  generate
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[gi] <= 1'b0;
          else     chain[gi] <= chain[gi-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/freqc_counter.sv
module freqc_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q,
  output logic         at_max
);
  always_ff @(posedge clk) begin
    if (rst || clr) q <= '0;
    else if (inc)   q <= q + 1'b1;
  end

  assign at_max = &q;
endmodule

// File: rtl/freqc_top.sv
module freqc_top
  import freqc_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int TICK_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sig_in,
  input  logic              arm,
  input  logic [CNT_W-1:0]  period_cmp,
  output logic [TICK_W-1:0] ticks_out,
  output logic              done,
  output logic              overflow
);
  localparam logic [CNT_W-1:0] CMP_ONE = CNT_W'(1);

  freqc_state_e      state_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [CNT_W-1:0]  edge_q;
  logic [TICK_W-1:0] tick_q;
  logic              tick_full;
  logic              edge_full;
  logic              rise;
  logic              gate_open;
  logic              edge_clr;
  logic              edge_inc;
  logic              tick_clr;
  logic              tick_inc;
  logic              hit_cmp;

  freqc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (sig_in),
    .rise     (rise)
  );

  // Edge path is blocked except while waiting or running.
  assign gate_open = !arm && (state_q == ST_WAIT || state_q == ST_RUN);
  assign edge_clr  = arm || state_q == ST_CLEAR;
  assign edge_inc  = gate_open && rise;
  assign tick_clr  = arm || state_q != ST_RUN;
  assign tick_inc  = !arm && state_q == ST_RUN;
  assign hit_cmp   = (edge_q + CMP_ONE) == cmp_q;

  freqc_counter #(.W(CNT_W)) u_edges (
    .clk    (clk),
    .rst    (rst),
    .clr    (edge_clr),
    .inc    (edge_inc),
    .q      (edge_q),
    .at_max (edge_full)
  );

  freqc_counter #(.W(TICK_W)) u_ticks (
    .clk    (clk),
    .rst    (rst),
    .clr    (tick_clr),
    .inc    (tick_inc),
    .q      (tick_q),
    .at_max (tick_full)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cmp_q     <= '0;
      ticks_out <= '0;
      done      <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        state_q  <= ST_CLEAR;
        cmp_q    <= period_cmp;
        overflow <= 1'b0;
      end else begin
        unique case (state_q)
          ST_IDLE:  state_q <= ST_IDLE;
          ST_CLEAR: state_q <= ST_WAIT;
          ST_WAIT: begin
            if (rise) begin
              if (cmp_q <= CMP_ONE) begin
                ticks_out <= '0;
                done      <= 1'b1;
                state_q   <= ST_IDLE;
              end else begin
                state_q <= ST_RUN;
              end
            end
          end
          ST_RUN: begin
            if (tick_full || (edge_full && rise)) begin
              ticks_out <= '1;
              overflow  <= 1'b1;
              done      <= 1'b1;
              state_q   <= ST_IDLE;
            end else if (rise && hit_cmp) begin
              ticks_out <= tick_q + 1'b1;
              done      <= 1'b1;
              state_q   <= ST_IDLE;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/freqc_chk.sv
module freqc_chk #(
  parameter int TICK_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              arm,
  input logic [TICK_W-1:0] ticks_out,
  input logic              done,
  input logic              overflow
);
  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(ticks_out));

  // R8
  ovf_value_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (&ticks_out));

  // R8
  ovf_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> done);

  // R6
  arm_clears_chk: assert property (@(posedge clk) disable iff (rst)
    arm |=> (!done && !overflow));
endmodule

bind freqc_top freqc_chk #(.TICK_W(TICK_W)) u_freqc_chk (
  .clk       (clk),
  .rst       (rst),
  .arm       (arm),
  .ticks_out (ticks_out),
  .done      (done),
  .overflow  (overflow)
);

// File: tb/freqc_top_bench.sv
module freqc_top_bench;
  localparam int CNT_W  = 32;
  localparam int TICK_W = 12;
  localparam logic [TICK_W-1:0] TMAX = '1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sig_in;
  logic              arm = 1'b0;
  logic [CNT_W-1:0]  period_cmp = '0;
  logic [TICK_W-1:0] ticks_out;
  logic              done;
  logic              overflow;

  int total = 0;
  int bad   = 0;
  int cycles = 0;

  // generator controls
  logic gen_en = 1'b0;
  int   hi_len = 2;
  int   lo_len = 2;
  int   gcnt   = 0;

  freqc_top #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_freqc_top (
    .clk        (clk),
    .rst        (rst),
    .sig_in     (sig_in),
    .arm        (arm),
    .period_cmp (period_cmp),
    .ticks_out  (ticks_out),
    .done       (done),
    .overflow   (overflow)
  );

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (!gen_en) begin
      gcnt   <= 0;
      sig_in <= 1'b0;
    end else begin
      sig_in <= (gcnt < hi_len);
      gcnt   <= (gcnt + 1 >= hi_len + lo_len) ? 0 : gcnt + 1;
    end
  end

  // {hi, lo, cmp, expected ticks}
  localparam int NVEC = 5;
  localparam int VEC [NVEC][4] = '{
    '{2, 2, 11, 40},
    '{3, 4,  5, 28},
    '{1, 2, 21, 60},
    '{5, 5,  2, 10},
    '{1, 5,  9, 48}
  };

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_arm(input int cmp);
    @(negedge clk);
    gen_en     = 1'b0;
    period_cmp = CNT_W'(cmp);
    arm        = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_done(input int limit, output bit seen, output logic [TICK_W-1:0] val);
    seen = 0;
    val  = '0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        val  = ticks_out;
        break;
      end
    end
  endtask

  initial begin
    while (cycles < 200000) begin
      @(posedge clk);
      cycles++;
    end
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=<200000", cycles);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit seen;
    logic [TICK_W-1:0] got;
    logic [TICK_W-1:0] held;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 done", done, 0);
    check("R1 overflow", overflow, 0);
    check("R1 ticks", ticks_out, 0);

    // R2 / R3 / R10 vector walk
    for (int v = 0; v < NVEC; v++) begin
      do_arm(VEC[v][2]);
      hi_len = VEC[v][0];
      lo_len = VEC[v][1];
      gen_en = 1'b1;
      wait_done(2000, seen, got);
      check("R2 done seen", seen, 1);
      check("R2 R10 ticks", got, VEC[v][3]);
      @(negedge clk);
      check("R3 done one cycle", done, 0);
    end

    // R4: edges after completion ignored
    held = ticks_out;
    repeat (60) @(negedge clk);
    check("R4 ticks held", ticks_out, held);
    check("R4 no extra done", done, 0);

    // R5: cmp changed after arm
    do_arm(6);
    period_cmp = CNT_W'(50);
    hi_len = 2; lo_len = 3; gen_en = 1'b1;
    wait_done(2000, seen, got);
    check("R5 ticks use latched cmp", got, 25);

    // R6: arm aborts a run in progress
    do_arm(30);
    hi_len = 3; lo_len = 3; gen_en = 1'b1;
    repeat (40) @(negedge clk);
    do_arm(4);
    check("R6 no done after arm", done, 0);
    hi_len = 4; lo_len = 4; gen_en = 1'b1;
    wait_done(2000, seen, got);
    check("R6 fresh result", got, 24);

    // R7: cmp 1 and 0
    do_arm(1);
    hi_len = 2; lo_len = 2; gen_en = 1'b1;
    wait_done(200, seen, got);
    check("R7 cmp1 done", seen, 1);
    check("R7 cmp1 ticks", got, 0);
    do_arm(0);
    hi_len = 2; lo_len = 2; gen_en = 1'b1;
    wait_done(200, seen, got);
    check("R7 cmp0 ticks", got, 0);

    // R9: no edges -> no done
    do_arm(5);
    held = ticks_out;
    wait_done(300, seen, got);
    check("R9 no done", seen, 0);
    check("R9 ticks unchanged", ticks_out, held);

    // R8: overflow
    do_arm(100);
    hi_len = 50; lo_len = 50; gen_en = 1'b1;
    wait_done(6000, seen, got);
    check("R8 done on overflow", seen, 1);
    check("R8 overflow flag", overflow, 1);
    check("R8 ticks saturate", got, TMAX);
    repeat (20) @(negedge clk);
    check("R8 overflow held", overflow, 1);
    do_arm(3);
    check("R6 R8 overflow cleared by arm", overflow, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule